// File: doc/BRIEF.md
# Character and Control Register Bank for a Bus-Attached Display

This block is the storage side of a small alphanumeric display peripheral. A host processor reaches it like any other memory-mapped peripheral: a 3-bit address, an 8-bit data path split into input, output and output-enable, a pair of chip enables of opposite polarity, and active-low read and write strobes. Behind that interface sit four character words, one for each display position, and a single control word. The stored contents are presented continuously to the downstream display logic.

Each character word packs a 7-bit character code in bits 6:0 and a per-position attribute-select flag in bit 7. The upper half of the address map (address bit 2 high) selects a character position with bits 1:0, where position 0 is the rightmost and position 3 the leftmost. The lower half (address bit 2 low) reaches the single control word at all four addresses. Writing the control word with bit 7 set wipes every stored bit, the control word included. A second control write with bit 7 low is then needed to load real settings. After a clear, and after the following re-arming write, the host must leave about a microsecond before the next access. All other accesses may run back to back. Contents after power-up are undefined, and the reset input does not clear them.

The strobes are sampled on the block clock by a three-state bus sequencer. S_IDLE moves to S_WR_HOLD on a selected write strobe (transition T_WRITE), and this is the only cycle that stores data. S_IDLE moves to S_READ on a selected read strobe with the write strobe high (T_READ). S_READ moves to S_WR_HOLD if a write strobe arrives (T_READ_TO_WRITE), and back to S_IDLE when the read ends or the device is deselected (T_READ_END). S_WR_HOLD returns to S_IDLE once the write strobe rises or the device is deselected (T_WRITE_END). Reset forces S_IDLE.

Top module: `charreg_bank`

## Requirements
- R1: The device is selected only when ce0_n is 0 and ce1 is 1. In any other combination no register changes and data_oe stays 0, whatever the strobes do.
- R2: data_oe is 1 exactly while the device is selected, rd_n is 0 and wr_n is 1. In that state data_out carries the addressed register in the same cycle.
- R3: With addr[2]=0, addresses 0 to 3 all reach the one control word. A write to any of them updates it, and a read from any of them returns it.
- R4: With addr[2]=1, addr[1:0] selects character position 0 to 3. A write stores the byte there, and the outputs show it from the next cycle on: char_codes[7*i+6:7*i] carries bits 6:0 and char_attr[i] carries bit 7.
- R5: One write strobe low period stores exactly one byte, on the first clock edge that sees it. Data changed later in the same low period is not stored.
- R6: A control write with bit 7 = 1 sets all four character words and the control word to zero on that edge. A later control write with bit 7 = 0 loads the control word normally.
- R7: When rd_n and wr_n are both 0 on a selected device, the write takes place and data_oe stays 0.
- R8: Asserting rst_n low leaves all stored contents unchanged and returns the bus sequencer to idle with data_oe at 0.
- R9: ctrl_word always shows the stored control word, from the cycle after the write that set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the bus sequencer only |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address; bit 2 picks characters (1) or control (0) |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data toward the host, zero when not driving |
| data_oe | output | 1 | Output enable for the external tri-state driver |
| char_codes | output | 28 | Packed 7-bit character codes, position 0 in the low bits |
| char_attr | output | 4 | Attribute-select flag of each position |
| ctrl_word | output | 8 | Current control word |

## Verification
Assertions check on every cycle that data_oe never rises while the device is deselected or while the write strobe is low. They also check that a write pulse never lasts two cycles, that a clearing control write leaves every register zero on the following cycle, and that each ordinary write lands in exactly the addressed register. Only the bench scenarios can show the following: the aliasing of the control word seen through reads at all four low addresses, rejection of writes under each of the three non-selecting enable combinations, the first-edge capture while data moves under a held strobe, and the survival of stored contents across a reset pulse.

// File: rtl/charreg_pkg.sv
package charreg_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_READ    = 2'd1,
        S_WR_HOLD = 2'd2
    } bus_state_t;
endpackage

// File: rtl/charreg_bus_seq.sv
module charreg_bus_seq
    import charreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_pulse,
    output logic rd_drive
);
    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (sel && !wr_n)      state_d = S_WR_HOLD;   // T_WRITE
                else if (sel && !rd_n) state_d = S_READ;      // T_READ
            end
            S_READ: begin
                if (sel && !wr_n)      state_d = S_WR_HOLD;   // T_READ_TO_WRITE
                else if (!sel || rd_n) state_d = S_IDLE;      // T_READ_END
            end
            S_WR_HOLD: begin
                if (!sel || wr_n)      state_d = S_IDLE;      // T_WRITE_END
            end
            default:                   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_pulse = sel && !wr_n && (state_q != S_WR_HOLD);
        rd_drive = sel && !rd_n && wr_n;
    end

    // R5: a strobe low period yields a single-cycle write
    p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R5: a held strobe keeps the sequencer parked
    p_hold_parks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && $past(1'b1)) |=> (state_q == S_WR_HOLD));
endmodule

// File: rtl/charreg_store.sv
module charreg_store #(
    parameter int NUM_DIGITS = 4,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = $clog2(NUM_DIGITS) + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            ctrl_q,
    output logic [NUM_DIGITS*DATA_W-1:0] dig_flat
);
    localparam int SEL_W   = ADDR_W - 1;
    localparam int CLR_BIT = DATA_W - 1;

    logic is_ctrl;
    logic wipe;

    assign is_ctrl = !waddr[ADDR_W-1];
    assign wipe    = wr_en && is_ctrl && wdata[CLR_BIT];

    always_ff @(posedge clk) begin
        if (wr_en && is_ctrl)
            ctrl_q <= wipe ? '0 : wdata;
    end

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        logic [DATA_W-1:0] dig_q;
        logic              hit;

        assign hit = wr_en && !is_ctrl && (waddr[SEL_W-1:0] == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (wipe)     dig_q <= '0;
            else if (hit) dig_q <= wdata;
        end

        assign dig_flat[i*DATA_W +: DATA_W] = dig_q;

        // R4: a position write lands in its own word
        p_digit_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && waddr[ADDR_W-1] && (waddr[SEL_W-1:0] == SEL_W'(i)))
            |=> (dig_q == $past(wdata)));

        // R6: a clearing control write zeroes this position
        p_digit_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !waddr[ADDR_W-1] && wdata[CLR_BIT]) |=> (dig_q == '0));
    end

    // R3: any low address updates the control word
    p_ctrl_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !waddr[ADDR_W-1] && !wdata[CLR_BIT]) |=> (ctrl_q == $past(wdata)));

    // R6: a clearing write leaves the control word at zero
    p_ctrl_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !waddr[ADDR_W-1] && wdata[CLR_BIT]) |=> (ctrl_q == '0));
endmodule

// File: rtl/charreg_rdmux.sv
module charreg_rdmux #(
    parameter int NUM_DIGITS = 4,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = $clog2(NUM_DIGITS) + 1
) (
    input  logic [ADDR_W-1:0]            raddr,
    input  logic [DATA_W-1:0]            ctrl_q,
    input  logic [NUM_DIGITS*DATA_W-1:0] dig_flat,
    output logic [DATA_W-1:0]            rdata
);
    localparam int SEL_W = ADDR_W - 1;

    always_comb begin
        if (raddr[ADDR_W-1])
            rdata = dig_flat[raddr[SEL_W-1:0]*DATA_W +: DATA_W];
        else
            rdata = ctrl_q;
    end
endmodule

// File: rtl/charreg_bank.sv
module charreg_bank #(
    parameter int NUM_DIGITS = 4,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = $clog2(NUM_DIGITS) + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ce0_n,
    input  logic                             ce1,
    input  logic                             rd_n,
    input  logic                             wr_n,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                data_in,
    output logic [DATA_W-1:0]                data_out,
    output logic                             data_oe,
    output logic [NUM_DIGITS*(DATA_W-1)-1:0] char_codes,
    output logic [NUM_DIGITS-1:0]            char_attr,
    output logic [DATA_W-1:0]                ctrl_word
);
    localparam int CODE_W = DATA_W - 1;

    logic                         sel;
    logic                         wr_pulse;
    logic                         rd_drive;
    logic [DATA_W-1:0]            ctrl_q;
    logic [NUM_DIGITS*DATA_W-1:0] dig_flat;
    logic [DATA_W-1:0]            rdata;

    assign sel = !ce0_n && ce1;

    charreg_bus_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wr_pulse (wr_pulse),
        .rd_drive (rd_drive)
    );

    charreg_store #(.NUM_DIGITS(NUM_DIGITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_pulse),
        .waddr    (addr),
        .wdata    (data_in),
        .ctrl_q   (ctrl_q),
        .dig_flat (dig_flat)
    );

    charreg_rdmux #(.NUM_DIGITS(NUM_DIGITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .raddr    (addr),
        .ctrl_q   (ctrl_q),
        .dig_flat (dig_flat),
        .rdata    (rdata)
    );

    assign data_oe   = rd_drive;
    assign data_out  = rd_drive ? rdata : '0;
    assign ctrl_word = ctrl_q;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_split
        assign char_codes[i*CODE_W +: CODE_W] = dig_flat[i*DATA_W +: CODE_W];
        assign char_attr[i]                   = dig_flat[i*DATA_W + CODE_W];
    end

    // R1: no bus drive while deselected
    p_no_drive_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce0_n || !ce1) |-> !data_oe);

    // R7: a low write strobe always wins over reading
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !data_oe);

    // R9: a deselected cycle leaves the control word alone
    p_ctrl_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce0_n) && $past(rst_n)) |-> $stable(ctrl_word) || $isunknown($past(ctrl_word)));
endmodule

// File: tb/sim_charreg_bank.sv
module sim_charreg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce0_n = 1'b1;
    logic        ce1 = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [27:0] char_codes;
    logic [3:0]  char_attr;
    logic [7:0]  ctrl_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_ctrl;
    logic [7:0] exp_dig [4];

    always #10 clk = ~clk;

    charreg_bank u0 (
        .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1(ce1), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .char_codes(char_codes), .char_attr(char_attr), .ctrl_word(ctrl_word)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        if (!a[2]) begin
            if (d[7]) begin
                exp_ctrl = '0;
                for (int i = 0; i < 4; i++) exp_dig[i] = '0;
            end else begin
                exp_ctrl = d;
            end
        end else begin
            exp_dig[a[1:0]] = d;
        end
    endtask

    task automatic bus_write(input logic c0n, input logic c1, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        ce0_n = c0n; ce1 = c1; addr = a; data_in = d; rd_n = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        ce0_n = 1'b1; ce1 = 1'b0;
        if (!c0n && c1) model_write(a, d);
    endtask

    task automatic bus_read(input logic c0n, input logic c1, input logic [2:0] a,
                            output logic [7:0] d, output logic oe);
        @(negedge clk);
        ce0_n = c0n; ce1 = c1; addr = a; rd_n = 1'b0; wr_n = 1'b1;
        #2;
        d = data_out; oe = data_oe;
        @(negedge clk);
        rd_n = 1'b1; ce0_n = 1'b1; ce1 = 1'b0;
    endtask

    task automatic check_outputs(input string tag);
        for (int i = 0; i < 4; i++) begin
            chk(char_codes[i*7 +: 7] == exp_dig[i][6:0], {tag, " R4 code"},
                32'(char_codes[i*7 +: 7]), 32'(exp_dig[i][6:0]));
            chk(char_attr[i] == exp_dig[i][7], {tag, " R4 attr"},
                32'(char_attr[i]), 32'(exp_dig[i][7]));
        end
        chk(ctrl_word == exp_ctrl, {tag, " R9 ctrl_word"}, 32'(ctrl_word), 32'(exp_ctrl));
    endtask

    task automatic check_reads(input string tag);
        logic [7:0] d;
        logic       oe;
        for (int a = 0; a < 8; a++) begin
            bus_read(1'b0, 1'b1, 3'(a), d, oe);
            chk(oe == 1'b1, {tag, " R2 oe"}, 32'(oe), 32'd1);
            if (a < 4) chk(d == exp_ctrl, {tag, " R3 alias read"}, 32'(d), 32'(exp_ctrl));
            else       chk(d == exp_dig[a-4], {tag, " R2 digit read"}, 32'(d), 32'(exp_dig[a-4]));
        end
    endtask

    initial begin
        logic [7:0] d;
        logic       oe;
        exp_ctrl = '0;
        for (int i = 0; i < 4; i++) exp_dig[i] = '0;

        repeat (3) @(negedge clk);
        chk(data_oe == 1'b0, "R8 reset oe", 32'(data_oe), 32'd0);
        chk(data_out == 8'h00, "R8 reset data_out", 32'(data_out), 32'd0);
        rst_n = 1'b1;

        // R6: initial wipe brings undefined contents to zero
        bus_write(1'b0, 1'b1, 3'd2, 8'h80);
        check_outputs("R6 first wipe");
        check_reads("R6 first wipe");

        // R3 R4: sweep every address with computed data
        for (int r = 0; r < 3; r++) begin
            for (int a = 0; a < 8; a++) begin
                logic [7:0] v;
                v = 8'((a * 53 + r * 29 + 7) & 8'hFF);
                if (a < 4) v[7] = 1'b0;
                bus_write(1'b0, 1'b1, 3'(a), v);
                check_outputs("R4 sweep");
            end
            check_reads("R3 sweep");
        end

        // R1: every non-selecting enable pair rejects writes and reads
        for (int c = 0; c < 3; c++) begin
            logic c0n, c1v;
            c0n = (c != 2);
            c1v = (c == 1);
            for (int a = 0; a < 8; a++) begin
                bus_write(c0n, c1v, 3'(a), (a < 4) ? 8'h5A : 8'hA5);
                bus_read(c0n, c1v, 3'(a), d, oe);
                chk(oe == 1'b0, "R1 deselected oe", 32'(oe), 32'd0);
                chk(d == 8'h00, "R1 deselected data_out", 32'(d), 32'd0);
            end
            check_outputs("R1 deselected");
        end

        // R5: data changing under a held strobe is not stored
        @(negedge clk);
        ce0_n = 1'b0; ce1 = 1'b1; addr = 3'd5; data_in = 8'h41; wr_n = 1'b0;
        @(negedge clk);
        data_in = 8'h7E;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        ce0_n = 1'b1; ce1 = 1'b0;
        exp_dig[1] = 8'h41;
        chk(char_codes[13:7] == 7'h41, "R5 held strobe", 32'(char_codes[13:7]), 32'h41);
        check_outputs("R5 held strobe");

        // R7: both strobes low writes and keeps the bus quiet
        @(negedge clk);
        ce0_n = 1'b0; ce1 = 1'b1; addr = 3'd7; data_in = 8'hC3; wr_n = 1'b0; rd_n = 1'b0;
        #2;
        chk(data_oe == 1'b0, "R7 both low oe", 32'(data_oe), 32'd0);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; ce0_n = 1'b1; ce1 = 1'b0;
        exp_dig[3] = 8'hC3;
        check_outputs("R7 both low");

        // R6: clear after loaded data, then re-arm with clear low
        bus_write(1'b0, 1'b1, 3'd1, 8'hB6);
        check_outputs("R6 clear");
        chk(ctrl_word == 8'h00, "R6 ctrl after clear", 32'(ctrl_word), 32'd0);
        bus_write(1'b0, 1'b1, 3'd3, 8'h33);
        chk(ctrl_word == 8'h33, "R6 rearm", 32'(ctrl_word), 32'h33);
        check_reads("R6 rearm");

        // R8: reset pulse keeps contents
        bus_write(1'b0, 1'b1, 3'd4, 8'h53);
        bus_write(1'b0, 1'b1, 3'd6, 8'hD4);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(data_oe == 1'b0, "R8 oe in reset", 32'(data_oe), 32'd0);
        rst_n = 1'b1;
        check_outputs("R8 after reset");
        check_reads("R8 after reset");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule